// File: doc/BRIEF.md
# Load-Pulse to Chip-Select Stretcher

This block sits between a set of external serial pins and an internal SPI slave. Serial data in, serial clock in and serial data out pass straight through as wires. The external load line is different. It is high for only one serial-clock cycle in each frame, but the SPI slave needs a select that stays asserted for the whole transfer. The block turns each load pulse into a sticky select.

The block runs on a fast system clock that oversamples the serial clock. The serial clock and the load pin each go through a two-flop synchronizer. The synchronized clock is then compared with a registered copy of itself to find falling edges. When a falling edge coincides with a high load level, the select is set. The select stays set while falling edges keep arriving. A saturating timeout counter restarts on every falling edge. When it reaches its terminal count, the serial clock has been idle for too long, and the select is dropped.

None of the pins carries a stream, so the block has no valid/ready handshake and cannot apply back-pressure. Every pin is a plain level, and the serial master sets the pace.

Top module: `load_sel_stretch`

## Requirements
- R1: `core_sdi` equals `pad_sdi` at all times, with no register in the path.
- R2: `core_sclk` equals `pad_sclk` at all times, with no register in the path.
- R3: `pad_sdo` equals `core_sdo` at all times, with no register in the path.
- R4: The pins are sampled on every rising edge of the system clock. Suppose the sample taken at edge n shows `pad_sclk` = 0 and `pad_load` = 1, and the sample at edge n-1 showed `pad_sclk` = 1. Then `core_sel` is 1 after edge n+2.
- R5: Once `core_sel` is 1, it stays 1 while sampled falling edges keep arriving, even when `pad_load` is low at those edges.
- R6: Each sampled falling edge restarts the timeout. Suppose the last falling edge was in the sample taken at edge n and no other event intervenes. Then `core_sel` is still 1 after edge n+2+TC_COUNT and is 0 after edge n+3+TC_COUNT.
- R7: A high `pad_load` level with no sampled falling edge of `pad_sclk` never asserts `core_sel`.
- R8: The timeout counter saturates and does not wrap. After a timeout, `core_sel` stays 0 for any length of idle time. A later falling edge sampled with load high asserts it again, as R4 describes.
- R9: While `rst` is high at a clock edge, `core_sel` is 0 after that edge, and the synchronizer, edge and counter state are cleared.
- R10: A sampled falling edge with `pad_load` = 0 does not assert `core_sel` when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_sdi | input | 1 | External serial data in |
| pad_sclk | input | 1 | External serial clock |
| pad_load | input | 1 | External one-cycle-per-frame load pulse |
| core_sdo | input | 1 | Serial data out from the internal SPI slave |
| core_sdi | output | 1 | Serial data in to the internal SPI slave |
| core_sclk | output | 1 | Serial clock to the internal SPI slave |
| pad_sdo | output | 1 | External serial data out |
| core_sel | output | 1 | Stretched, active-high chip select to the internal SPI slave |

## Verification
The assertions assume a serial clock and a load line that change slowly compared with the system clock. Each level must last for several system cycles so that the synchronizer sees every transition. They also assume that load changes only while the serial clock is low, so that load is sampled together with the low clock.

The stimulus holds every serial-clock phase for four system cycles. It changes load only at the falling edge and back at the rising edge. It drives the pins low before each reset, so the model's sample history and the cleared synchronizer agree.

// File: rtl/lss_pkg.sv
package lss_pkg;
  // Number of synchronizer stages on the asynchronous pins
  localparam int unsigned SYNC_STAGES = 2;

  // Pins that cross into the system-clock domain
  typedef struct packed {
    logic sclk;
    logic load;
  } pin_samp_t;

  localparam int unsigned SAMP_W = $bits(pin_samp_t);
endpackage

// File: rtl/lss_sync.sv
module lss_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lss_edge.sv
module lss_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  // Current level low while the previous level was high
  assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/lss_timeout.sv
module lss_timeout #(
  parameter int unsigned TC = 254,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic          expired,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TERM = CW'(TC);

  always_ff @(posedge clk) begin
    if (rst || restart)  count <= '0;
    else if (!expired)   count <= count + 1'b1;
  end

  assign expired = (count == TERM);
endmodule

// File: rtl/lss_select.sv
module lss_select (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic drop,
  output logic sel
);
  always_ff @(posedge clk) begin
    if (rst)          sel <= 1'b0;
    else if (set_req) sel <= 1'b1;
    else if (drop)    sel <= 1'b0;
  end
endmodule

// File: rtl/load_sel_stretch.sv
module load_sel_stretch #(
  parameter int unsigned TC_COUNT = 254
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_sdi,
  input  logic pad_sclk,
  input  logic pad_load,
  input  logic core_sdo,
  output logic core_sdi,
  output logic core_sclk,
  output logic pad_sdo,
  output logic core_sel
);
  import lss_pkg::*;

  localparam int unsigned CW = $clog2(TC_COUNT + 1);

  // Straight-through paths (R1, R2, R3)
  assign core_sdi  = pad_sdi;
  assign core_sclk = pad_sclk;
  assign pad_sdo   = core_sdo;

  pin_samp_t raw_s, syn_s;
  logic      fall_w, tmo_w, set_w;
  logic [CW-1:0] cnt_w;

  assign raw_s.sclk = pad_sclk;
  assign raw_s.load = pad_load;

  lss_sync #(.W(SAMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_s), .q(syn_s)
  );

  lss_edge u_edge (
    .clk(clk), .rst(rst), .lvl(syn_s.sclk), .fall(fall_w)
  );

  lss_timeout #(.TC(TC_COUNT), .CW(CW)) u_tmo (
    .clk(clk), .rst(rst), .restart(fall_w), .expired(tmo_w), .count(cnt_w)
  );

  assign set_w = fall_w & syn_s.load;

  lss_select u_sel (
    .clk(clk), .rst(rst), .set_req(set_w), .drop(tmo_w), .sel(core_sel)
  );
endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
  parameter int unsigned TC = 254,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          pad_sdi,
  input logic          core_sdi,
  input logic          pad_sclk,
  input logic          core_sclk,
  input logic          core_sdo,
  input logic          pad_sdo,
  input logic          core_sel,
  input logic          fall,
  input logic          load_s,
  input logic          tmo,
  input logic [CW-1:0] cnt
);
  a_r1_sdi_pass: assert property (@(posedge clk) disable iff (rst)
    core_sdi == pad_sdi);
  a_r2_sclk_pass: assert property (@(posedge clk) disable iff (rst)
    core_sclk == pad_sclk);
  a_r3_sdo_pass: assert property (@(posedge clk) disable iff (rst)
    pad_sdo == core_sdo);
  a_r4_set_on_load: assert property (@(posedge clk) disable iff (rst)
    (fall && load_s) |=> core_sel);
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (core_sel && !tmo) |=> core_sel);
  a_r6_drop_on_timeout: assert property (@(posedge clk) disable iff (rst)
    (tmo && !(fall && load_s)) |=> !core_sel);
  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    (!core_sel && !(fall && load_s)) |=> !core_sel);
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(TC) && !fall) |=> (cnt == CW'(TC)));
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !core_sel);
endmodule

bind load_sel_stretch lss_checker #(.TC(TC_COUNT), .CW(CW)) u_chk (
  .clk(clk), .rst(rst),
  .pad_sdi(pad_sdi), .core_sdi(core_sdi),
  .pad_sclk(pad_sclk), .core_sclk(core_sclk),
  .core_sdo(core_sdo), .pad_sdo(pad_sdo),
  .core_sel(core_sel),
  .fall(fall_w), .load_s(syn_s.load), .tmo(tmo_w), .cnt(cnt_w)
);

// File: tb/load_sel_stretch_test.sv
module load_sel_stretch_test;
  localparam int TC = 254;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pad_sdi = 1'b0, pad_sclk = 1'b0, pad_load = 1'b0, core_sdo = 1'b0;
  logic core_sdi, core_sclk, pad_sdo, core_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  load_sel_stretch #(.TC_COUNT(TC)) uut (
    .clk(clk), .rst(rst), .pad_sdi(pad_sdi), .pad_sclk(pad_sclk),
    .pad_load(pad_load), .core_sdo(core_sdo), .core_sdi(core_sdi),
    .core_sclk(core_sclk), .pad_sdo(pad_sdo), .core_sel(core_sel)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: sample history, last restart edge, select
  int  edge_no = 0;
  int  last_clr = 0;
  logic exp_sel = 1'b0;
  logic [2:0] h_clk = '0;
  logic [2:0] h_ld  = '0;

  always @(posedge clk) begin
    edge_no++;
    if (rst) begin
      h_clk = '0; h_ld = '0; last_clr = edge_no; exp_sel = 1'b0;
    end else begin
      bit ev, timed_out;
      ev = !h_clk[1] && h_clk[2];
      timed_out = (edge_no - 1 - last_clr) >= TC;
      if (ev && h_ld[1]) exp_sel = 1'b1;
      else if (timed_out) exp_sel = 1'b0;
      if (ev) last_clr = edge_no;
      h_clk = {h_clk[1:0], pad_sclk};
      h_ld  = {h_ld[1:0], pad_load};
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R4/R5/R6 select vs model", core_sel, exp_sel);
      check("R1 sdi pass", core_sdi, pad_sdi);
      check("R2 sclk pass", core_sclk, pad_sclk);
      check("R3 sdo pass", pad_sdo, core_sdo);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_cycle(input logic ld, input logic d);
    pad_sclk = 1'b1; pad_sdi = d; core_sdo = ~d;
    wait_cyc(HALF);
    pad_sclk = 1'b0; pad_load = ld;
    wait_cyc(HALF);
    pad_load = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    wait_cyc(6);
    check("R9 select low in reset", core_sel, 1'b0);
    rst = 1'b0;
    wait_cyc(3);
    // R10: edges with load low never set the select
    for (int i = 0; i < 6; i++) sclk_cycle(1'b0, i[0]);
    check("R10 no set without load", core_sel, 1'b0);
    // R7: load high with clock parked high
    pad_sclk = 1'b1; wait_cyc(3); pad_load = 1'b1; wait_cyc(10);
    check("R7 load without edge", core_sel, 1'b0);
    pad_load = 1'b0; wait_cyc(3);
    // R4: frame start
    sclk_cycle(1'b1, 1'b1);
    check("R4 select asserted", core_sel, 1'b1);
    // R5: transfer continues with load low
    for (int i = 0; i < 24; i++) sclk_cycle(1'b0, i[1]);
    check("R5 select held", core_sel, 1'b1);
    sclk_cycle(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) sclk_cycle(1'b0, i[0]);
    check("R5 held across second frame", core_sel, 1'b1);
    // R6: clock stops; select holds then drops
    pad_sclk = 1'b1;
    wait_cyc(TC - 10);
    check("R6 still held before timeout", core_sel, 1'b1);
    wait_cyc(30);
    check("R6 dropped after timeout", core_sel, 1'b0);
    // R8: long idle, no wrap, then reassert
    wait_cyc(3 * TC);
    check("R8 stays low after saturation", core_sel, 1'b0);
    sclk_cycle(1'b1, 1'b1);
    check("R8 reasserts on new frame", core_sel, 1'b1);
    for (int i = 0; i < 4; i++) sclk_cycle(1'b0, 1'b1);
    // R9: reset mid-transfer
    pad_sclk = 1'b0; pad_load = 1'b0; pad_sdi = 1'b0; core_sdo = 1'b0;
    wait_cyc(1);
    rst = 1'b1; wait_cyc(3);
    check("R9 reset clears select", core_sel, 1'b0);
    wait_cyc(2);
    rst = 1'b0; wait_cyc(3);
    for (int i = 0; i < 3; i++) sclk_cycle(1'b0, 1'b0);
    check("R9 stays low after reset", core_sel, 1'b0);
    sclk_cycle(1'b1, 1'b0);
    check("R4 asserts after reset", core_sel, 1'b1);
    wait_cyc(4);
    finish_run();
  end
endmodule